// File: doc/BRIEF.md
# Oscillator warm-up interval counter

This block times the stabilization delay of an oscillator that has just been enabled, before the system clock is moved onto it. A cascade of a low byte and a high byte forms one up-counter. It advances on rising edges of a chosen source clock. Each source-clock input is asynchronous to the register clock. It passes through a synchronizer and an edge detector before it can move the count. The direction select picks the source. The slow-clock direction, which moves from the fast clock to the slow clock, counts the slow oscillator. The reverse direction counts the fast oscillator.

The comparison uses only the high byte of the setting word, so the delay is programmed in steps of one full low-byte wrap. This is 256 source edges with the default widths. When the step count is reached, the block raises a sticky interrupt request and restarts its count from zero. Software sets the run bit to start a measurement and clears it to stop. Clearing the run bit also empties the count. In this mode the timer flip-flop output is held low, so no pulse appears on the pins that share it.

Top module: `wup_interval_timer`

## Requirements
- R1: After reset, the interrupt request output `irq` is 0 and the timer output `tff_out` is 0.
- R2: The count advances by one only on a synchronized rising edge of the selected source, and only while both `run` and `src_en` are 1. With a setting whose high byte H is non-zero, `irq` rises after exactly H × 2^LO_W counted edges (H × 256 by default), and it is still 0 after one edge fewer.
- R3: The low LO_W bits of `setting` have no effect. Settings that differ only in those bits give the same interval.
- R4: A high byte of 0 is treated as 2^HI_W steps, which gives an interval of 2^(HI_W+LO_W) edges. It does not match at start.
- R5: While `run` is 0, the count is held at zero. After a restart, a full interval is needed again, whatever had been counted before.
- R6: `irq` stays at 1 until `irq_ack` is 1 at a clock edge. It is then 0 from the next cycle on.
- R7: When a match and `irq_ack` fall on the same clock edge, the match wins and `irq` is 1 afterwards.
- R8: With `dir_sel` = 0 the block counts edges of `slow_src`. With `dir_sel` = 1 it counts edges of `fast_src`. Edges on the source that is not selected are not counted.
- R9: `tff_out` is 0 in every cycle.
- R10: On a match, the count returns to zero and counting goes on. The next `irq` needs a further full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start (1) or stop and clear (0) the measurement |
| dir_sel | input | 1 | Switching direction: 0 counts slow_src, 1 counts fast_src |
| src_en | input | 1 | Source-clock enable; when it is 0, edges are not counted |
| slow_src | input | 1 | Slow oscillator clock, asynchronous |
| fast_src | input | 1 | Fast oscillator clock, asynchronous |
| setting | input | HI_W+LO_W | Interval setting; only the high HI_W bits are compared |
| irq_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Sticky interrupt request set on a match |
| tff_out | output | 1 | Timer flip-flop output, held low in this mode |

## Verification
The final counted edge, which sets the request, can land on the same clock edge as a software acknowledge of an earlier request. The bench provokes this collision on purpose. It leaves a previous request pending, feeds one edge less than the interval, and then raises `irq_ack` for exactly the one register-clock cycle in which the synchronized edge reaches the counter. The result is judged correct only if `irq` reads 1 afterwards, since a lost request here would hang a clock switch. Randomized settings, with random low bits and random directions, are checked against a bench function that computes the interval from the high byte alone.

// File: rtl/wup_pkg.sv
// Shared definitions for the oscillator warm-up interval counter.
// Assumes two clock sources; the index of a source equals its select code.
package wup_pkg;
    localparam int WUP_NSRC         = 2;
    localparam int WUP_SYNC_STAGES  = 2;

    typedef enum logic {
        SRC_SLOW = 1'b0,
        SRC_FAST = 1'b1
    } wup_src_e;
endpackage

// File: rtl/wup_edge_sync.sv
// Brings an asynchronous clock input into the register clock domain and
// emits a one-cycle pulse per rising edge. Assumes the source stays high and
// low for at least one register clock period each.
module wup_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] shreg;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], din};
    end

    // A rising edge appears once the synchronized level is new.
    always_comb rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/wup_counter.sv
// Cascaded low/high byte up-counter. Only the high part is compared with the
// high part of the setting, at the moment the low part wraps. A high setting
// of zero means 2^HI_W steps. It clears on a match or whenever run is low.
module wup_counter #(
    parameter int HI_W = 8,
    parameter int LO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 step,
    input  logic [HI_W-1:0]      setting_hi,
    output logic                 hit,
    output logic [HI_W+LO_W-1:0] cnt
);
    localparam int CW = HI_W + LO_W;

    logic [HI_W:0] target;
    logic [HI_W:0] hi_next;
    logic          lo_full;

    // Number of high-part steps to wait; zero selects the full range.
    always_comb begin
        if (setting_hi == '0) target = {1'b1, {HI_W{1'b0}}};
        else                  target = {1'b0, setting_hi};
    end

    // Detect the wrap of the low part that completes the programmed steps.
    always_comb begin
        lo_full = &cnt[LO_W-1:0];
        hi_next = {1'b0, cnt[CW-1:LO_W]} + {{HI_W{1'b0}}, 1'b1};
        hit     = step && lo_full && (hi_next == target);
    end

    // Count register: cleared when stopped or on a match, else advances.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || hit)  cnt <= '0;
        else if (step)         cnt <= cnt + {{(CW-1){1'b0}}, 1'b1};
    end
endmodule

// File: rtl/wup_interval_timer.sv
// Top of the oscillator warm-up interval counter. Synchronizes both source
// clocks, selects one by direction, gates it with run and enable, counts,
// and holds a sticky interrupt request. The timer output stays low in this
// mode. Assumes software clears run before it switches clocks.
module wup_interval_timer
    import wup_pkg::*;
#(
    parameter int HI_W = 8,
    parameter int LO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 dir_sel,
    input  logic                 src_en,
    input  logic                 slow_src,
    input  logic                 fast_src,
    input  logic [HI_W+LO_W-1:0] setting,
    input  logic                 irq_ack,
    output logic                 irq,
    output logic                 tff_out
);
    localparam int CW = HI_W + LO_W;

    logic [WUP_NSRC-1:0] src_vec;
    logic [WUP_NSRC-1:0] src_rise;
    logic                step;
    logic                hit;
    logic [CW-1:0]       cnt;
    logic                unused_setting_lo;
    wup_src_e            src_sel;

    // Gather the sources so that the select code indexes them.
    always_comb begin
        src_vec[SRC_SLOW] = slow_src;
        src_vec[SRC_FAST] = fast_src;
        src_sel           = wup_src_e'(dir_sel);
    end

    for (genvar i = 0; i < WUP_NSRC; i++) begin : g_sync
        wup_edge_sync #(.STAGES(WUP_SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (src_vec[i]),
            .rise (src_rise[i])
        );
    end

    // Qualify the selected edge with run and the source enable.
    always_comb step = run && src_en && src_rise[src_sel];

    wup_counter #(.HI_W(HI_W), .LO_W(LO_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .step      (step),
        .setting_hi(setting[CW-1:LO_W]),
        .hit       (hit),
        .cnt       (cnt)
    );

    // Sticky request: a match has priority over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (hit)     irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end

    // Low setting bits do not take part in the interval.
    always_comb unused_setting_lo = &{1'b0, setting[LO_W-1:0]};

    // The pulse output stays quiet while this mode is in use.
    always_comb tff_out = 1'b0;
endmodule

// File: rtl/wup_checker.sv
// Property checker for the warm-up interval counter, bound to the top.
module wup_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          src_en,
    input logic          irq_ack,
    input logic          hit,
    input logic          irq,
    input logic [CW-1:0] cnt
);
    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !hit) |=> !irq);

    assert_match_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> irq);

    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    assert_gate_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !src_en) |=> $stable(cnt));

    assert_match_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt == '0));
endmodule

bind wup_interval_timer wup_checker #(.CW(HI_W + LO_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .src_en (src_en),
    .irq_ack(irq_ack),
    .hit    (hit),
    .irq    (irq),
    .cnt    (cnt)
);

// File: tb/sim_wup_interval_timer.sv
module sim_wup_interval_timer;
    localparam int HI_W = 8;
    localparam int LO_W = 4;
    localparam int CW   = HI_W + LO_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          dir_sel = 1'b0;
    logic          src_en = 1'b0;
    logic          slow_src = 1'b0;
    logic          fast_src = 1'b0;
    logic [CW-1:0] setting = '0;
    logic          irq_ack = 1'b0;
    logic          irq;
    logic          tff_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wup_interval_timer #(.HI_W(HI_W), .LO_W(LO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .dir_sel(dir_sel),
        .src_en(src_en), .slow_src(slow_src), .fast_src(fast_src),
        .setting(setting), .irq_ack(irq_ack), .irq(irq), .tff_out(tff_out)
    );

    // Interval in source edges, computed from the high byte only.
    function automatic int exp_edges(input logic [CW-1:0] s);
        int h;
        h = int'(s[CW-1:LO_W]);
        if (h == 0) h = 1 << HI_W;
        return h * (1 << LO_W);
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One rising edge on the chosen source (0 slow, 1 fast), 4 clocks long.
    task automatic pulse(input logic which);
        @(negedge clk);
        if (which) fast_src = 1'b1; else slow_src = 1'b1;
        repeat (2) @(negedge clk);
        if (which) fast_src = 1'b0; else slow_src = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulses(input logic which, input int n);
        for (int k = 0; k < n; k++) pulse(which);
    endtask

    task automatic ack;
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic restart;
        @(negedge clk); run = 1'b0;
        @(negedge clk); run = 1'b1;
    endtask

    // Count one interval: one edge short, then the last edge.
    task automatic interval(input logic which, input string req);
        int n;
        n = exp_edges(setting);
        pulses(which, n - 1);
        check(irq, 1'b0, req);
        pulse(which);
        check(irq, 1'b1, req);
    endtask

    always @(negedge clk) if (rst_n && !done) begin
        if (tff_out !== 1'b0) check(tff_out, 1'b0, "R9");
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        check(irq, 1'b0, "R1");
        check(tff_out, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(irq, 1'b0, "R1");

        // R2: basic interval on the slow source.
        setting = {8'h02, 4'h0};
        dir_sel = 1'b0; src_en = 1'b1; run = 1'b1;
        interval(1'b0, "R2");

        // R6: sticky, then acknowledged.
        repeat (10) @(negedge clk);
        check(irq, 1'b1, "R6");
        ack();
        check(irq, 1'b0, "R6");

        // R10: counting continues after the match.
        interval(1'b0, "R10");
        ack();

        // R3: low bits ignored.
        setting = {8'h01, 4'hF};
        restart();
        interval(1'b0, "R3");
        ack();

        // R2: src_en low blocks counting.
        setting = {8'h01, 4'h0};
        restart();
        src_en = 1'b0;
        pulses(1'b0, 20);
        check(irq, 1'b0, "R2");
        src_en = 1'b1;
        interval(1'b0, "R2");
        ack();

        // R8: unselected source ignored; fast source counted.
        dir_sel = 1'b1;
        restart();
        pulses(1'b0, 40);
        check(irq, 1'b0, "R8");
        interval(1'b1, "R8");
        ack();

        // R5: stopping clears progress.
        dir_sel = 1'b0;
        restart();
        pulses(1'b0, 10);
        restart();
        interval(1'b0, "R5");
        ack();

        // R4: zero high byte means the full range.
        setting = {8'h00, 4'hB};
        restart();
        interval(1'b0, "R4");

        // R7: match and acknowledge on the same edge, irq pending.
        setting = {8'h01, 4'h3};
        restart();
        pulses(1'b0, exp_edges(setting) - 1);
        check(irq, 1'b1, "R7");
        @(negedge clk); slow_src = 1'b1;
        @(negedge clk);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; slow_src = 1'b0;
        repeat (2) @(negedge clk);
        check(irq, 1'b1, "R7");
        ack();
        check(irq, 1'b0, "R6");

        // Random settings and directions.
        for (int t = 0; t < 6; t++) begin
            logic [7:0] h;
            h = 8'(($urandom % 6) + 1);
            setting = {h, 4'($urandom)};
            dir_sel = 1'($urandom);
            restart();
            interval(dir_sel, dir_sel ? "R8" : "R2");
            ack();
        end

        check(tff_out, 1'b0, "R9");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule